// File: doc/BRIEF.md
# Translation Table Update Engine

This block runs maintenance commands against an external I/O address translation table. A command carries a code, a bus address, a value (or, for the list command, the base address of an entry list in memory) and a page count. The engine aligns the bus address down to a page boundary. It turns the address into a table index relative to the window's bus offset and checks that index against the table size. It then reads or writes the table through a simple index/data port.

Four commands exist. A single put writes one entry. A get reads one entry back. A fill writes one value into a run of consecutive pages. A list put fetches 64-bit entries one at a time over a request/response memory port and writes each one to the next page. Every successful table write is announced on a notification port, so that cached translations for that page can be dropped. Multi-entry commands stop at the first entry that fails. While a command runs, the engine holds `busy` and ignores new commands. Each command ends with a one-cycle `doneValid` pulse that carries a success or parameter-error status.

Top module: `xlat_update_engine`

## Requirements
- R1: The bus address of every command is aligned down to a page boundary (low PAGE_SHIFT bits cleared) before use, so an address anywhere inside a page selects that page.
- R2: The table index is (aligned address − BUS_OFFSET) >> PAGE_SHIFT, computed modulo 2^AW. An index at or beyond TABLE_SIZE gives doneErr=1 with no table write.
- R3: Every table write raises notifyValid in the same cycle. The notification carries the aligned bus address, the written value with its low PAGE_SHIFT bits cleared, an offset mask of PAGE_SIZE−1, and permission = value bits [1:0].
- R4: cmdCode 0 (put) writes cmdValue at the index and ends with doneErr=0.
- R5: cmdCode 1 (get) returns the stored entry on getData with doneErr=0, or doneErr=1 with no write when the index is out of range.
- R6: cmdCode 2 (fill) with a count above TABLE_SIZE ends with doneErr=1 and no write. Otherwise it writes cmdValue to `count` consecutive pages, advancing one page per step.
- R7: cmdCode 3 (list) with a count above LIST_MAX (512), or with a list address whose bits [11:0] are not zero, ends with doneErr=1 with no memory fetch and no write.
- R8: A list step k fetches from (list address with bits [1:0] cleared) + 8·k. The step holds memReq until memRsp arrives, then writes the returned word to page k after the start page.
- R9: A fill or list command stops at the first step whose index is out of range and reports doneErr=1. Entries written by earlier steps stay written.
- R10: busy is high from the cycle after a command is accepted until its doneValid pulse. cmdValid is ignored while busy. doneValid pulses exactly once per accepted command.
- R11: A fill or list command with a count of zero writes nothing and ends with doneErr=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when not busy |
| cmdCode | input | 2 | 0 put, 1 get, 2 fill, 3 list |
| cmdAddr | input | AW | Bus address |
| cmdValue | input | 64 | Entry value, or list base address for list |
| cmdCount | input | CW | Page count for fill and list |
| busy | output | 1 | Command in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | 1 = parameter error, 0 = success |
| getData | output | 64 | Entry returned by get |
| tblWrEn | output | 1 | Table write strobe |
| tblIdx | output | IW | Table index for read and write |
| tblWrData | output | 64 | Table write data |
| tblRdData | input | 64 | Table read data for tblIdx, same cycle |
| memReq | output | 1 | List fetch request, held until response |
| memAddr | output | AW | List fetch address |
| memRsp | input | 1 | List fetch response strobe |
| memRdata | input | 64 | List fetch data |
| notifyValid | output | 1 | Invalidation notification strobe |
| notifyIova | output | AW | Page-aligned bus address written |
| notifyXlat | output | 64 | Written value with page offset cleared |
| notifyMask | output | 64 | Page offset mask |
| notifyPerm | output | 2 | Permission bits of the written value |

## Verification
The bench targets the range limits of the index. It uses an address just below the window offset, which wraps to a huge index, and the first page past the table. A design that subtracted without wrapping, or that compared with > instead of >=, would write a stray entry. Fill and list runs are started near the top of the table so that they cross the boundary. A design that checked only the first index, or that rolled back after the failure, would show the wrong table contents or a wrong write count. Zero counts, over-limit counts and misaligned list bases are sent to catch a missing error preset or a fetch made before the checks. A command is also injected while the engine is busy, to catch a controller that takes it and corrupts a table entry.

// File: rtl/xlat_upd_pkg.sv
package xlat_upd_pkg;

  typedef enum logic [1:0] {
    CMD_PUT  = 2'd0,
    CMD_GET  = 2'd1,
    CMD_FILL = 2'd2,
    CMD_LIST = 2'd3
  } cmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic write;
    logic advance;
    logic readLatch;
    logic fetchLatch;
    logic setOk;
    logic setErr;
  } strobe_t;

endpackage

// File: rtl/xlat_upd_dp.sv
module xlat_upd_dp
  import xlat_upd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 10,
  parameter int IW         = 4,
  parameter int TABLE_SIZE = 16,
  parameter int PAGE_SHIFT = 12,
  parameter logic [AW-1:0] BUS_OFFSET = 32'h0001_0000,
  parameter int LIST_MAX   = 512
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [1:0]    cmdCode,
  input  logic [AW-1:0] cmdAddr,
  input  logic [63:0]   cmdValue,
  input  logic [CW-1:0] cmdCount,
  input  logic [63:0]   memRdata,
  input  logic [63:0]   tblRdData,
  output cmd_e          codeReg,
  output logic          preBad,
  output logic          stepsDone,
  output logic          idxBad,
  output logic          doneErr,
  output logic [63:0]   getData,
  output logic          tblWrEn,
  output logic [IW-1:0] tblIdx,
  output logic [63:0]   tblWrData,
  output logic [AW-1:0] memAddr,
  output logic          notifyValid,
  output logic [AW-1:0] notifyIova,
  output logic [63:0]   notifyXlat,
  output logic [63:0]   notifyMask,
  output logic [1:0]    notifyPerm
);

  localparam logic [AW-1:0] PAGE_STEP = AW'(1) << PAGE_SHIFT;
  localparam logic [AW-1:0] OFS_MASK  = PAGE_STEP - AW'(1);
  localparam logic [63:0]   OFS_MASK64 = (64'd1 << PAGE_SHIFT) - 64'd1;

  logic [AW-1:0] curAddr;
  logic [63:0]   valueReg;
  logic [63:0]   fetchReg;
  logic [CW-1:0] countReg;
  logic [CW-1:0] stepCnt;
  logic          errReg;
  logic [63:0]   getReg;

  logic [AW-1:0] idxFull;
  logic [AW-1:0] listBase;
  logic [63:0]   wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      valueReg <= '0;
      fetchReg <= '0;
      countReg <= '0;
      stepCnt  <= '0;
      codeReg  <= CMD_PUT;
      errReg   <= 1'b0;
      getReg   <= '0;
    end else begin
      if (st.load) begin
        curAddr  <= cmdAddr & ~OFS_MASK;
        valueReg <= cmdValue;
        countReg <= cmdCount;
        codeReg  <= cmd_e'(cmdCode);
        stepCnt  <= '0;
        errReg   <= 1'b1;   // status preset to error
      end
      if (st.advance) begin
        curAddr <= curAddr + PAGE_STEP;
        stepCnt <= stepCnt + CW'(1);
      end
      if (st.fetchLatch) fetchReg <= memRdata;
      if (st.readLatch)  getReg   <= tblRdData;
      if (st.setOk)      errReg   <= 1'b0;
      if (st.setErr)     errReg   <= 1'b1;
    end
  end

  always_comb begin
    idxFull  = (curAddr - BUS_OFFSET) >> PAGE_SHIFT;
    idxBad   = idxFull >= AW'(TABLE_SIZE);
    listBase = valueReg[AW-1:0] & ~AW'(3);
    wrData   = (codeReg == CMD_LIST) ? fetchReg : valueReg;
    unique case (codeReg)
      CMD_FILL: preBad = 32'(countReg) > 32'(TABLE_SIZE);
      CMD_LIST: preBad = (32'(countReg) > 32'(LIST_MAX)) || (valueReg[11:0] != 12'd0);
      default:  preBad = 1'b0;
    endcase
    if (codeReg == CMD_PUT || codeReg == CMD_GET) stepsDone = stepCnt != '0;
    else                                          stepsDone = stepCnt == countReg;
  end

  assign memAddr     = listBase + (AW'(stepCnt) << 3);
  assign tblWrEn     = st.write;
  assign tblIdx      = idxFull[IW-1:0];
  assign tblWrData   = wrData;
  assign doneErr     = errReg;
  assign getData     = getReg;
  assign notifyValid = st.write;
  assign notifyIova  = curAddr;
  assign notifyXlat  = wrData & ~OFS_MASK64;
  assign notifyMask  = OFS_MASK64;
  assign notifyPerm  = wrData[1:0];

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tblWrEn |-> (idxFull < AW'(TABLE_SIZE))) else $error("write out of range"); // R2
  AST_NOTIFY_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> ((notifyIova & OFS_MASK) == '0)) else $error("unaligned iova"); // R1
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (tblWrEn && codeReg == CMD_FILL) |-> (32'(countReg) <= 32'(TABLE_SIZE))) else $error("fill over size"); // R6
  AST_LIST_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    st.fetchLatch |-> (stepCnt < countReg && 32'(countReg) <= 32'(LIST_MAX) && valueReg[11:0] == 12'd0))
    else $error("bad list fetch"); // R7

endmodule

// File: rtl/xlat_upd_ctl.sv
module xlat_upd_ctl
  import xlat_upd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  cmd_e    codeReg,
  input  logic    preBad,
  input  logic    stepsDone,
  input  logic    idxBad,
  input  logic    memRsp,
  output strobe_t st,
  output logic    busy,
  output logic    doneValid,
  output logic    memReq
);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_FETCH, S_WRITE, S_DONE} state_e;
  state_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    st        = '0;
    stateNxt  = state;
    memReq    = 1'b0;
    doneValid = 1'b0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        st.load  = 1'b1;
        stateNxt = S_CHECK;
      end
      S_CHECK: begin
        if (preBad || stepsDone) begin
          stateNxt = S_DONE;
        end else if (idxBad) begin
          st.setErr = 1'b1;
          stateNxt  = S_DONE;
        end else begin
          unique case (codeReg)
            CMD_GET: begin
              st.readLatch = 1'b1;
              st.setOk     = 1'b1;
              stateNxt     = S_DONE;
            end
            CMD_LIST: stateNxt = S_FETCH;
            default: begin
              st.write   = 1'b1;
              st.setOk   = 1'b1;
              st.advance = 1'b1;
            end
          endcase
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memRsp) begin
          st.fetchLatch = 1'b1;
          stateNxt      = S_WRITE;
        end
      end
      S_WRITE: begin
        st.write   = 1'b1;
        st.setOk   = 1'b1;
        st.advance = 1'b1;
        stateNxt   = S_CHECK;
      end
      S_DONE: begin
        doneValid = 1'b1;
        stateNxt  = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy = state != S_IDLE;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid) else $error("done held"); // R10
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !st.load) else $error("load while busy"); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRsp) |=> memReq) else $error("request dropped"); // R8

endmodule

// File: rtl/xlat_update_engine.sv
module xlat_update_engine
  import xlat_upd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 10,
  parameter int TABLE_SIZE = 16,
  parameter int PAGE_SHIFT = 12,
  parameter logic [AW-1:0] BUS_OFFSET = 32'h0001_0000,
  parameter int LIST_MAX   = 512,
  localparam int IW        = (TABLE_SIZE > 1) ? $clog2(TABLE_SIZE) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdCode,
  input  logic [AW-1:0] cmdAddr,
  input  logic [63:0]   cmdValue,
  input  logic [CW-1:0] cmdCount,
  output logic          busy,
  output logic          doneValid,
  output logic          doneErr,
  output logic [63:0]   getData,
  output logic          tblWrEn,
  output logic [IW-1:0] tblIdx,
  output logic [63:0]   tblWrData,
  input  logic [63:0]   tblRdData,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic          memRsp,
  input  logic [63:0]   memRdata,
  output logic          notifyValid,
  output logic [AW-1:0] notifyIova,
  output logic [63:0]   notifyXlat,
  output logic [63:0]   notifyMask,
  output logic [1:0]    notifyPerm
);

  strobe_t st;
  cmd_e    codeReg;
  logic    preBad, stepsDone, idxBad;

  xlat_upd_ctl i_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .codeReg(codeReg),
    .preBad(preBad), .stepsDone(stepsDone), .idxBad(idxBad), .memRsp(memRsp),
    .st(st), .busy(busy), .doneValid(doneValid), .memReq(memReq)
  );

  xlat_upd_dp #(
    .AW(AW), .CW(CW), .IW(IW), .TABLE_SIZE(TABLE_SIZE),
    .PAGE_SHIFT(PAGE_SHIFT), .BUS_OFFSET(BUS_OFFSET), .LIST_MAX(LIST_MAX)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .cmdCode(cmdCode), .cmdAddr(cmdAddr),
    .cmdValue(cmdValue), .cmdCount(cmdCount), .memRdata(memRdata),
    .tblRdData(tblRdData), .codeReg(codeReg), .preBad(preBad),
    .stepsDone(stepsDone), .idxBad(idxBad), .doneErr(doneErr),
    .getData(getData), .tblWrEn(tblWrEn), .tblIdx(tblIdx),
    .tblWrData(tblWrData), .memAddr(memAddr), .notifyValid(notifyValid),
    .notifyIova(notifyIova), .notifyXlat(notifyXlat),
    .notifyMask(notifyMask), .notifyPerm(notifyPerm)
  );

endmodule

// File: tb/test_xlat_update_engine.sv
module test_xlat_update_engine;

  localparam int AW = 32;
  localparam int CW = 10;
  localparam int TS = 16;
  localparam logic [31:0] OFF   = 32'h0001_0000;
  localparam logic [31:0] LBASE = 32'h0008_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdCode = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [63:0] cmdValue = '0;
  logic [CW-1:0] cmdCount = '0;
  logic busy, doneValid, doneErr, tblWrEn, memReq, notifyValid;
  logic [63:0] getData, tblWrData, tblRdData, notifyXlat, notifyMask;
  logic [63:0] memRdata = '0;
  logic memRsp = 1'b0;
  logic [3:0] tblIdx;
  logic [AW-1:0] memAddr, notifyIova;
  logic [1:0] notifyPerm;

  always #5 clk = ~clk;

  xlat_update_engine i_xlat_update_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdValue(cmdValue), .cmdCount(cmdCount),
    .busy(busy), .doneValid(doneValid), .doneErr(doneErr), .getData(getData),
    .tblWrEn(tblWrEn), .tblIdx(tblIdx), .tblWrData(tblWrData),
    .tblRdData(tblRdData), .memReq(memReq), .memAddr(memAddr),
    .memRsp(memRsp), .memRdata(memRdata), .notifyValid(notifyValid),
    .notifyIova(notifyIova), .notifyXlat(notifyXlat),
    .notifyMask(notifyMask), .notifyPerm(notifyPerm)
  );

  logic [63:0] tbl [TS];
  logic [63:0] model [TS];
  logic [63:0] listMem [32];
  int checks = 0;
  int fails = 0;
  int wrCount = 0;
  int fetchIdx = 0;
  int lat = 0;
  logic [31:0] curListBase = '0;

  assign tblRdData = tbl[tblIdx];
  always @(posedge clk) if (tblWrEn) tbl[tblIdx] <= tblWrData;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] idxOf(input logic [31:0] a);
    return ((a & ~32'hFFF) - OFF) >> 12;
  endfunction

  // Write and notification monitor
  always @(negedge clk) if (rstN && tblWrEn) begin
    logic [31:0] ix;
    wrCount++;
    ix = idxOf(notifyIova);
    chk(notifyValid, "R3 notifyValid with write", 64'(notifyValid), 64'd1);
    chk((notifyIova & 32'hFFF) == 0, "R1 iova aligned", 64'(notifyIova), 64'(notifyIova & ~32'hFFF));
    chk(ix < TS && tblIdx == ix[3:0], "R2 index from iova", 64'(tblIdx), 64'(ix));
    chk(notifyXlat == (tblWrData & ~64'hFFF), "R3 xlat", notifyXlat, tblWrData & ~64'hFFF);
    chk(notifyMask == 64'hFFF, "R3 mask", notifyMask, 64'hFFF);
    chk(notifyPerm == tblWrData[1:0], "R3 perm", 64'(notifyPerm), 64'(tblWrData[1:0]));
  end

  // List memory responder, two-cycle latency
  always @(negedge clk) begin
    if (memRsp) begin
      memRsp = 1'b0;
    end else if (rstN && memReq) begin
      if (lat == 2) begin
        chk(memAddr == curListBase + 32'(fetchIdx * 8), "R8 fetch address",
            64'(memAddr), 64'(curListBase + 32'(fetchIdx * 8)));
        memRdata = listMem[((memAddr - LBASE) >> 3) & 32'd31];
        memRsp = 1'b1;
        fetchIdx++;
        lat = 0;
      end else lat++;
    end else lat = 0;
  end

  task automatic run(input logic [1:0] code, input logic [31:0] addr, input logic [63:0] val,
                     input int cnt, input string tag, input bit intrude);
    bit expErr = 1'b1;
    int expWr = 0;
    logic [63:0] expGet = '0;
    logic [31:0] a = addr & ~32'hFFF;
    int t = 0;
    case (code)
      2'd0: if (idxOf(a) < TS) begin model[idxOf(a)] = val; expErr = 0; expWr = 1; end
      2'd1: if (idxOf(a) < TS) begin expGet = model[idxOf(a)]; expErr = 0; end
      2'd2: if (cnt <= TS) for (int i = 0; i < cnt; i++) begin
              if (idxOf(a + 32'(i) * 32'h1000) >= TS) begin expErr = 1; break; end
              model[idxOf(a + 32'(i) * 32'h1000)] = val; expErr = 0; expWr++;
            end
      default: if (cnt <= 512 && val[11:0] == 0) for (int i = 0; i < cnt; i++) begin
              if (idxOf(a + 32'(i) * 32'h1000) >= TS) begin expErr = 1; break; end
              model[idxOf(a + 32'(i) * 32'h1000)] = listMem[i]; expErr = 0; expWr++;
            end
    endcase
    wrCount = 0;
    fetchIdx = 0;
    curListBase = val[31:0] & ~32'd3;
    cmdCode = code; cmdAddr = addr; cmdValue = val; cmdCount = CW'(cnt); cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(busy, {tag, " R10 busy after accept"}, 64'(busy), 64'd1);
    if (intrude) begin
      @(negedge clk);
      cmdCode = 2'd0; cmdAddr = OFF + 32'hA000; cmdValue = 64'hDEAD_BEEF_0000_0003; cmdValid = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0;
    end
    while (!doneValid && t < 5000) begin @(negedge clk); t++; end
    chk(doneValid, {tag, " done seen"}, 64'(doneValid), 64'd1);
    chk(doneErr == expErr, {tag, " status"}, 64'(doneErr), 64'(expErr));
    if (code == 2'd1 && !expErr) chk(getData == expGet, {tag, " R5 get data"}, getData, expGet);
    chk(wrCount == expWr, {tag, " write count"}, 64'(wrCount), 64'(expWr));
    if (code == 2'd3 && (cnt > 512 || val[11:0] != 0))
      chk(fetchIdx == 0, {tag, " R7 no fetch"}, 64'(fetchIdx), 64'd0);
    @(negedge clk);
  endtask

  task automatic cmpTable(input string tag);
    for (int i = 0; i < TS; i++)
      chk(tbl[i] == model[i], {tag, " table entry"}, tbl[i], model[i]);
  endtask

  task automatic runAll();
    for (int i = 0; i < TS; i++) begin tbl[i] = '0; model[i] = '0; end
    for (int i = 0; i < 32; i++) listMem[i] = {32'hC0DE_0000 + 32'(i), 32'(i) * 32'h1111 + 32'(i % 4)};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !doneValid && !tblWrEn && !memReq && !notifyValid, "reset state", 64'(busy), 64'd0);
    // R4 R1 sweep of single puts with unaligned addresses
    for (int i = 0; i < TS; i++)
      run(2'd0, OFF + 32'(i) * 32'h1000 + 32'(i * 37 % 4096), 64'h1234_5000_0000_0000 + 64'(i * 4099), 1, "R4 put", 0);
    cmpTable("R4");
    // R2 out-of-range puts
    run(2'd0, OFF - 32'h1, 64'h55, 1, "R2 below offset", 0);
    run(2'd0, OFF + 32'(TS) * 32'h1000, 64'h66, 1, "R2 past end", 0);
    run(2'd0, 32'h0, 64'h77, 1, "R2 zero addr", 0);
    cmpTable("R2");
    // R5 gets
    for (int i = 0; i < TS; i++) run(2'd1, OFF + 32'(i) * 32'h1000 + 32'hFFF, 64'h0, 0, "R5 get", 0);
    run(2'd1, OFF + 32'(TS) * 32'h1000, 64'h0, 0, "R5 get out of range", 0);
    cmpTable("R5");
    // R11 zero counts, R6 fills
    run(2'd2, OFF, 64'hAAAA_0001, 0, "R11 fill zero", 0);
    run(2'd3, OFF, 64'(LBASE), 0, "R11 list zero", 0);
    run(2'd2, OFF, 64'hBBBB_0002, TS + 1, "R6 fill over size", 0);
    cmpTable("R6 R11");
    run(2'd2, OFF, 64'hCCCC_3003, TS, "R6 fill full", 0);
    run(2'd2, OFF + 32'h3456, 64'hDDDD_4001, 5, "R6 fill mid", 0);
    cmpTable("R6");
    run(2'd2, OFF + 32'hE000, 64'hEEEE_5002, 4, "R9 fill crossing end", 0);
    cmpTable("R9 fill");
    // R7 R8 lists
    run(2'd3, OFF, 64'(LBASE), 513, "R7 list over max", 0);
    run(2'd3, OFF, 64'(LBASE + 32'h10), 2, "R7 list misaligned", 0);
    cmpTable("R7");
    run(2'd3, OFF + 32'h2000, 64'(LBASE) | 64'h3, 8, "R8 list perm bits", 0);
    run(2'd3, OFF, 64'(LBASE), TS, "R8 list full", 0);
    cmpTable("R8");
    run(2'd3, OFF + 32'hD000, 64'(LBASE), 6, "R9 list crossing end", 0);
    cmpTable("R9 list");
    // R10 command offered while busy
    run(2'd2, OFF, 64'h1111_2221, 12, "R10 fill with intrusion", 1);
    cmpTable("R10");
    for (int i = 0; i < 10; i++) begin
      chk(!doneValid && !busy, "R10 no extra command", 64'(doneValid), 64'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule